// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Per-Bank-Index Rotation

This block decides when a DRAM controller must send a refresh command, and to which banks it applies. It has two modes. In normal mode, an interval timer adds one owed all-bank refresh per period. Each of these refreshes covers every bank in the device. In fine-granularity mode, the timer runs with a shorter period, and each owed refresh becomes a same-bank refresh. A same-bank refresh names one bank index and hits the bank with that index in every bank group at once.

The command arbiter sees a request that carries the refresh type and the bank index. The request stays unchanged until the arbiter grants it. From the grant cycle, the block drives two per-bank vectors:
- a lockout vector, which covers the refreshed banks for the refresh duration;
- an activate-block vector, which covers the banks not refreshed for the short refresh-to-activate delay that follows a same-bank refresh.

The arbiter uses both vectors to hold back traffic. Same-bank refreshes rotate through the bank indices. The order within a round follows bank availability, not a fixed sequence. A backlog counter raises an urgent flag when too many refreshes are owed.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and right after it, `ref_req`, `ref_urgent`, `bank_lockout` and `act_block` are all zero. The round mask starts with every index pending.
- R2: The interval timer adds one owed refresh every `T_AB_INT` cycles in normal mode and every `T_SB_INT` cycles in fine-granularity mode. With banks idle, `ref_req` rises one cycle after the owed count becomes nonzero. In normal mode the request is an all-bank refresh: `ref_same_bank`=0 and `ref_bank`=0.
- R3: Once raised, `ref_req`, `ref_same_bank` and `ref_bank` hold their values until `ref_grant` is sampled high. A `ref_grant` pulse while `ref_req` is low has no effect.
- R4: After an all-bank grant, every bit of `bank_lockout` is high for exactly `T_RFC_AB` cycles, starting the cycle after the grant edge.
- R5: In fine-granularity mode, the request names the lowest index that meets all three conditions: it is still pending in the current round, it is idle in every group, and it is not locked out. Bank b of group g is bit g*BANKS_PER_BG+b of every bank vector. `ref_same_bank`=1 marks a same-bank refresh.
- R6: No index gets a second same-bank refresh until every index has had one. After the last pending index is served, all indices become pending again.
- R7: After a same-bank grant for index b, only the bits for index b in every group rise in `bank_lockout`. They stay high for exactly `T_RFC_SB` cycles.
- R8: After a same-bank grant for index b, `act_block` is high for exactly `T_REFSBRD` cycles on every bank not of index b, and low on the banks of index b.
- R9: The owed count saturates at `MAX_OWED`. `ref_urgent` is high while the owed count is at least `URGENT_AT`.
- R10: A change on `fgr_mode` takes effect only when all three hold: no request is raised, no lockout is active, and no activate block is active. Taking effect restarts the timer and clears the owed count.
- R11: In normal mode, no request is raised while any bank is not idle or any lockout is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_idle | input | NUM_BG*BANKS_PER_BG | Per-bank idle (precharged, no data activity) |
| fgr_mode | input | 1 | 1 selects fine-granularity (same-bank) mode |
| ref_grant | input | 1 | Arbiter accepts the pending request |
| ref_req | output | 1 | Refresh request |
| ref_same_bank | output | 1 | 1 = same-bank refresh, 0 = all-bank refresh |
| ref_bank | output | BW | Bank index of a same-bank refresh |
| ref_urgent | output | 1 | Refresh backlog reached the urgent threshold |
| bank_lockout | output | NUM_BG*BANKS_PER_BG | Banks under refresh |
| act_block | output | NUM_BG*BANKS_PER_BG | Banks whose activates must wait after a same-bank refresh |

## Verification
The bench builds the block with 2 bank groups of 4 banks. The intervals are 40 and 10 cycles, the refresh durations 12 and 6 cycles, the refresh-to-activate delay 3 cycles, and the owed limit 4 with the urgent threshold at 3. These short intervals bring within reach, in a few hundred cycles:
- saturation of the owed count;
- a full same-bank round followed by the reload of the round mask;
- a blocked mode change during a lockout.

The bank vector is only 8 bits, so the exact lockout and activate-block patterns can be compared as whole words.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int NUM_BG       = 8,
  parameter int BANKS_PER_BG = 4,
  parameter int T_AB_INT     = 7800,
  parameter int T_SB_INT     = 975,
  parameter int T_RFC_AB     = 590,
  parameter int T_RFC_SB     = 260,
  parameter int T_REFSBRD    = 60,
  parameter int MAX_OWED     = 8,
  parameter int URGENT_AT    = 6,
  parameter int BW           = (BANKS_PER_BG > 1) ? $clog2(BANKS_PER_BG) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BG*BANKS_PER_BG-1:0] bank_idle,
  input  logic                           fgr_mode,
  input  logic                           ref_grant,
  output logic                           ref_req,
  output logic                           ref_same_bank,
  output logic [BW-1:0]                  ref_bank,
  output logic                           ref_urgent,
  output logic [NUM_BG*BANKS_PER_BG-1:0] bank_lockout,
  output logic [NUM_BG*BANKS_PER_BG-1:0] act_block
);
  localparam int NB    = NUM_BG * BANKS_PER_BG;
  localparam int T_MAX = (T_AB_INT > T_SB_INT) ? T_AB_INT : T_SB_INT;
  localparam int L_MAX = (T_RFC_AB > T_RFC_SB) ? T_RFC_AB : T_RFC_SB;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int LW    = $clog2(L_MAX + 1);
  localparam int SW    = $clog2(T_REFSBRD + 1);
  localparam int OW    = $clog2(MAX_OWED + 1);

  logic                    mode_q;
  logic [TW-1:0]           tmr;
  logic [OW-1:0]           owed;
  logic [BANKS_PER_BG-1:0] pend;
  logic [LW-1:0]           lock_cnt [BANKS_PER_BG];
  logic [BANKS_PER_BG-1:0] lock_nz;
  logic [BANKS_PER_BG-1:0] idx_free;
  logic [SW-1:0]           sbrd_cnt;
  logic [BW-1:0]           sbrd_idx;
  logic                    req_q, req_sb_q;
  logic [BW-1:0]           req_idx_q;
  logic                    pick_ok;
  logic [BW-1:0]           pick_idx;
  logic [BANKS_PER_BG-1:0] pend_nxt;

  wire take     = req_q & ref_grant;
  wire any_lock = |lock_nz;
  wire sbrd_on  = (sbrd_cnt != '0);
  wire quiet    = ~req_q & ~any_lock & ~sbrd_on;
  wire mode_chg = quiet & (fgr_mode != mode_q);
  wire [TW-1:0] period_m1 = mode_q ? TW'(T_SB_INT - 1) : TW'(T_AB_INT - 1);
  wire tick     = (tmr >= period_m1);
  wire ab_ok    = (&bank_idle) & ~any_lock;

  assign ref_req       = req_q;
  assign ref_same_bank = req_sb_q;
  assign ref_bank      = req_idx_q;
  assign ref_urgent    = (owed >= OW'(URGENT_AT));

  genvar gb, gg;
  generate
    for (gb = 0; gb < BANKS_PER_BG; gb++) begin : g_idx
      logic [NUM_BG-1:0] grp_idle;
      for (gg = 0; gg < NUM_BG; gg++) begin : g_grp
        assign grp_idle[gg]                      = bank_idle[gg*BANKS_PER_BG + gb];
        assign bank_lockout[gg*BANKS_PER_BG + gb] = lock_nz[gb];
        assign act_block[gg*BANKS_PER_BG + gb]    = sbrd_on & (sbrd_idx != BW'(gb));
      end
      assign lock_nz[gb]  = (lock_cnt[gb] != '0);
      assign idx_free[gb] = (&grp_idle) & ~lock_nz[gb];

      always_ff @(posedge clk) begin
        if (!rst_n)
          lock_cnt[gb] <= '0;
        else if (take && (!req_sb_q || req_idx_q == BW'(gb)))
          lock_cnt[gb] <= req_sb_q ? LW'(T_RFC_SB) : LW'(T_RFC_AB);
        else if (lock_nz[gb])
          lock_cnt[gb] <= lock_cnt[gb] - 1'b1;
      end
    end
  endgenerate

  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    for (int b = BANKS_PER_BG - 1; b >= 0; b--) begin
      if (pend[b] && idx_free[b]) begin
        pick_ok  = 1'b1;
        pick_idx = BW'(b);
      end
    end
  end

  always_comb begin
    pend_nxt = pend;
    pend_nxt[req_idx_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      tmr    <= '0;
      owed   <= '0;
    end else if (mode_chg) begin
      mode_q <= fgr_mode;
      tmr    <= '0;
      owed   <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick && !take && owed != OW'(MAX_OWED))
        owed <= owed + 1'b1;
      else if (take && !tick)
        owed <= owed - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      req_sb_q  <= 1'b0;
      req_idx_q <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && !mode_chg && owed != '0 && (mode_q ? pick_ok : ab_ok)) begin
      req_q     <= 1'b1;
      req_sb_q  <= mode_q;
      req_idx_q <= mode_q ? pick_idx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= '1;
    else if (take && req_sb_q)
      pend <= (pend_nxt == '0) ? '1 : pend_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbrd_cnt <= '0;
      sbrd_idx <= '0;
    end else if (take && req_sb_q) begin
      sbrd_cnt <= SW'(T_REFSBRD);
      sbrd_idx <= req_idx_q;
    end else if (sbrd_on) begin
      sbrd_cnt <= sbrd_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int NUM_BG       = 8,
  parameter int BANKS_PER_BG = 4,
  parameter int BW           = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_BG*BANKS_PER_BG-1:0] bank_idle,
  input logic                           ref_grant,
  input logic                           ref_req,
  input logic                           ref_same_bank,
  input logic [BW-1:0]                  ref_bank,
  input logic [NUM_BG*BANKS_PER_BG-1:0] bank_lockout,
  input logic [NUM_BG*BANKS_PER_BG-1:0] act_block
);
  localparam int NB = NUM_BG * BANKS_PER_BG;

  function automatic logic [NB-1:0] set_of(input logic [BW-1:0] idx);
    logic [NB-1:0] m;
    m = '0;
    for (int g = 0; g < NUM_BG; g++) m[g*BANKS_PER_BG + int'(idx)] = 1'b1;
    return m;
  endfunction

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> (ref_req && $stable(ref_same_bank) && $stable(ref_bank)));

  p_ab_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant && !ref_same_bank) |=> (&bank_lockout));

  p_sb_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant && ref_same_bank) |=>
      ((bank_lockout & set_of($past(ref_bank))) == set_of($past(ref_bank))));

  p_sb_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant && ref_same_bank) |=> (act_block == ~set_of($past(ref_bank))));

  p_ab_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_req) && !ref_same_bank) |-> ($past(&bank_idle) && bank_lockout == '0));

  p_sb_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_req) && ref_same_bank) |->
      (($past(bank_idle) & set_of(ref_bank)) == set_of(ref_bank)));
endmodule

bind refresh_sched refresh_sched_chk #(
  .NUM_BG(NUM_BG), .BANKS_PER_BG(BANKS_PER_BG), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .ref_grant(ref_grant),
  .ref_req(ref_req), .ref_same_bank(ref_same_bank), .ref_bank(ref_bank),
  .bank_lockout(bank_lockout), .act_block(act_block)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int NBG = 2, BPG = 4, NB = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, fgr_mode, ref_grant;
  logic [NB-1:0] bank_idle;
  logic          ref_req, ref_same_bank, ref_urgent;
  logic [1:0]    ref_bank;
  logic [NB-1:0] bank_lockout, act_block;

  refresh_sched #(
    .NUM_BG(NBG), .BANKS_PER_BG(BPG), .T_AB_INT(40), .T_SB_INT(10),
    .T_RFC_AB(12), .T_RFC_SB(6), .T_REFSBRD(3), .MAX_OWED(4), .URGENT_AT(3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .fgr_mode(fgr_mode),
    .ref_grant(ref_grant), .ref_req(ref_req), .ref_same_bank(ref_same_bank),
    .ref_bank(ref_bank), .ref_urgent(ref_urgent), .bank_lockout(bank_lockout),
    .act_block(act_block)
  );

  int cyc;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  logic [2:0] exp_q[$];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  task automatic push(input logic sb, input logic [1:0] idx);
    exp_q.push_back({sb, idx});
  endtask

  task automatic serve();
    int t = 0;
    while (!ref_req && t < 300) begin @(negedge clk); t++; end
    if (!ref_req) chk("R2 request never raised", 0, 1);
    else begin
      #1 ref_grant = 1'b1;
      @(posedge clk);
      #1 ref_grant = 1'b0;
    end
  endtask

  // monitor: pops the expected refresh when the grant goes out
  always @(posedge ref_grant) begin
    if (ref_req) begin
      if (exp_q.size() == 0) chk("R5/R6 unexpected refresh", {ref_same_bank, ref_bank}, 3'h7);
      else chk("R5/R6/R10 refresh type and index", {ref_same_bank, ref_bank}, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; fgr_mode = 0; ref_grant = 0; bank_idle = '1;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", ref_req, 0);
    chk("R1 urgent in reset", ref_urgent, 0);
    chk("R1 lockout in reset", bank_lockout, 0);
    chk("R1 act block in reset", act_block, 0);
    rst_n = 1;

    wait_cyc(4); ref_grant = 1;      // R3: stray grant with no request
    wait_cyc(5); ref_grant = 0;
    wait_cyc(40); chk("R2 no request before first interval", ref_req, 0);
    wait_cyc(41); chk("R2 request after interval", ref_req, 1);
    chk("R2 all-bank type", {ref_same_bank, ref_bank}, 0);
    wait_cyc(45); chk("R3 request held", ref_req, 1);
    chk("R4 no lockout before grant", bank_lockout, 0);
    push(0, 0); serve();
    wait_cyc(46); chk("R4 lockout first cycle", bank_lockout, 8'hFF);
    chk("R8 no act block after all-bank", act_block, 0);
    wait_cyc(57); chk("R4 lockout last cycle", bank_lockout, 8'hFF);
    wait_cyc(58); chk("R4 lockout released", bank_lockout, 0);

    wait_cyc(60); bank_idle = 8'hDF;
    wait_cyc(85); chk("R11 no request while bank busy", ref_req, 0);
    bank_idle = 8'hFF;
    wait_cyc(86); chk("R11 request once idle", ref_req, 1);
    push(0, 0); serve();

    wait_cyc(100); bank_idle = 8'hFE;
    wait_cyc(199); chk("R9 not urgent at two owed", ref_urgent, 0);
    wait_cyc(200); chk("R9 urgent at three owed", ref_urgent, 1);
    wait_cyc(285); bank_idle = 8'hFF;
    repeat (5) push(0, 0);
    fork
      repeat (5) serve();
      begin
        wait_cyc(288); fgr_mode = 1;   // R10: blocked by active lockout
        wait_cyc(290); chk("R9 urgent while backlog high", ref_urgent, 1);
        wait_cyc(296); fgr_mode = 0;
        wait_cyc(302); chk("R9 urgent drops below threshold", ref_urgent, 0);
      end
    join
    wait_cyc(355); chk("R9 owed saturated at limit", ref_req, 0);

    fgr_mode = 1; bank_idle = 8'hEF;
    wait_cyc(366); chk("R10 mode applied, no early request", ref_req, 0);
    wait_cyc(367); chk("R10 same-bank request after short interval", {ref_req, ref_same_bank}, 2'b11);
    chk("R5 lowest idle pending index", ref_bank, 1);
    push(1, 1); serve();
    wait_cyc(368); chk("R7 lockout only index set", bank_lockout, 8'h22);
    chk("R8 act block on other banks", act_block, 8'hDD);
    bank_idle = 8'hFF;
    wait_cyc(370); chk("R8 act block last cycle", act_block, 8'hDD);
    wait_cyc(371); chk("R8 act block released", act_block, 0);
    chk("R7 lockout still held", bank_lockout, 8'h22);
    wait_cyc(373); chk("R7 lockout last cycle", bank_lockout, 8'h22);
    wait_cyc(374); chk("R7 lockout released", bank_lockout, 0);

    push(1, 0); push(1, 2); push(1, 3); push(1, 0);
    repeat (4) serve();
    wait_cyc(cyc + 2);
    chk("R6 round served in full", exp_q.size(), 0);
    finish_run();
  end
endmodule